// File: doc/BRIEF.md
# Lockstep Output Comparator

This block watches a redundant pair of processing cores that execute the same program on the same inputs. Every clock cycle it compares the output bus of the primary core with the output bus of the shadow core. Any bit that differs raises a fault toward the safety management logic, which then asks for a reset or a safe state.

The shadow core may run a fixed number of cycles behind the primary core. The lag is 0 to 3 cycles, and 0 means both buses are compared in the same cycle. The primary bus passes through a short register delay line, and the tap that matches the selected lag feeds the comparator. After a reset, and after any change of the lag setting, comparison is held off until the delay line holds data that lines up with the shadow stream.

The fault output stays set until reset. On the first discrepancy the block records the cycle index and the XOR pattern between the two aligned words. During self-test, an injection input can invert one selected bit of the shadow path, so the comparator itself can be proven to work.

Top module: `lockstep_cmp`

## Requirements
- R1: With the lag at 0, a cycle in which `main_bus` and `shadow_bus` differ, with comparison enabled, sets `fault` at the next rising clock edge. Identical buses never set it.
- R2: A difference in any single bit position 0 to 31 is detected, and `cap_diff` then shows exactly that bit set.
- R3: With lag L (1 to 3), the word `shadow_bus` carries in cycle t is compared against `main_bus` from cycle t-L. A shadow stream delayed by exactly L raises no fault. A stream aligned to any other lag raises one.
- R4: Counting cycles from the first cycle after reset release as cycle 0, comparison is enabled in cycle t only when rst_n was high and lag_cfg held one value in each of the cycles t-L-1 through t. Mismatches in blocked cycles have no effect on `fault`.
- R5: Once set, `fault` stays high until a synchronous reset (rst_n low at a rising edge) clears it.
- R6: On the first detected mismatch, `cap_cycle` takes the index of that cycle, counted as in R4. `cap_diff` takes the XOR of the aligned primary word and the shadow word. Later mismatches leave both unchanged.
- R7: While `inj_en` is high, bit `inj_bit` of the shadow word is inverted before the compare. While `inj_en` is low, `inj_bit` has no effect.
- R8: After reset, `fault` is 0, `cap_cycle` is 0 and `cap_diff` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lag_cfg | input | 2 | Number of cycles the shadow core runs behind the primary core (0 to 3) |
| main_bus | input | 32 | Output bus of the primary core |
| shadow_bus | input | 32 | Output bus of the shadow core |
| inj_en | input | 1 | Enables inversion of one shadow bit for self-test |
| inj_bit | input | 5 | Index of the shadow bit inverted when `inj_en` is high |
| fault | output | 1 | Sticky mismatch flag toward safety management |
| cap_cycle | output | 16 | Cycle index of the first mismatch (saturating) |
| cap_diff | output | 32 | XOR pattern of the first mismatch |

## Verification
The primary stream is random words. The shadow stream is built in four ways:
- Delayed by exactly the configured lag. This shows that the alignment is correct, because no fault may appear.
- Delayed by a wrong lag. This shows that the tap selection is real and not a pass-through.
- Given a single flipped bit at each of the 32 positions in turn. This separates full-width detection from a compare that misses some lanes.
- Filled with random garbage during the fill window after reset and after lag changes. This tells a correct hold-off apart from one that is too short or too long by one cycle.

Injection is tried alone, disabled with random indices, and against a real single-bit flip that it cancels. A long random mix of lag changes, resets and sparse corruption then checks the capture registers against a bench model.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the lockstep comparator.
// Assumes: lag values never exceed LSC_MAX_LAG.
package lsc_pkg;
    localparam int LSC_DATA_W  = 32;
    localparam int LSC_MAX_LAG = 3;
    localparam int LSC_CNT_W   = 16;
    localparam int LSC_LAG_W   = $clog2(LSC_MAX_LAG + 1);
endpackage

// File: rtl/lsc_delay_line.sv
`timescale 1ns/1ps
// Module: lsc_delay_line
// Delays the primary bus through MAX_LAG register stages. It outputs the
// tap selected by lag: 0 gives the live input, k gives the value from k
// cycles back.
// Assumes: lag <= MAX_LAG; the stage contents right after reset are
// don't-care because the alignment control blocks comparison then.
module lsc_delay_line #(
    parameter int DATA_W  = 32,
    parameter int MAX_LAG = 3,
    localparam int LAG_W  = $clog2(MAX_LAG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAG_W-1:0]  lag,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] tap
);
    logic [DATA_W-1:0] stage [MAX_LAG];
    logic              past_ok;

    generate
        for (genvar k = 0; k < MAX_LAG; k++) begin : g_stage
            if (k == 0) begin : g_first
                // Capture the live primary word.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= din;
                end
            end else begin : g_next
                // Shift the word one stage further back.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[k] <= '0;
                    else        stage[k] <= stage[k-1];
                end
            end
        end
    endgenerate

    // Select the stage matching the configured lag.
    always_comb begin
        tap = din;
        for (int k = 1; k <= MAX_LAG; k++) begin
            if (int'(lag) == k) tap = stage[k-1];
        end
    end

    // Marks that at least one clock has passed since reset, for $past use.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: a one-cycle lag must present the previous cycle's input.
    p_tap_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lag == LAG_W'(1)) |-> (tap == $past(din)));
endmodule

// File: rtl/lsc_align_ctrl.sv
`timescale 1ns/1ps
// Module: lsc_align_ctrl
// Decides in which cycles the comparison is valid. It tracks the previous
// lag setting and counts how many cycles the delay line has been filling
// since reset or the last lag change.
// Assumes: lag_cfg is sampled every cycle; a change restarts the fill.
module lsc_align_ctrl #(
    parameter int MAX_LAG = 3,
    localparam int LAG_W  = $clog2(MAX_LAG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAG_W-1:0] lag_cfg,
    output logic             cmp_en
);
    logic             armed;
    logic [LAG_W-1:0] lag_q;
    logic [LAG_W-1:0] fill;
    logic             lag_same;

    assign lag_same = (lag_cfg == lag_q);

    // Remember that a full cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Track the lag used in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lag_q <= '0;
        else        lag_q <= lag_cfg;
    end

    // Count filled delay stages, restarting on reset or lag change.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fill <= '0;
        else if (!armed || !lag_same)   fill <= '0;
        else if (int'(fill) < MAX_LAG)  fill <= fill + LAG_W'(1);
    end

    // Enable the compare once the selected tap holds aligned data.
    always_comb begin
        cmp_en = armed && lag_same && (fill >= lag_cfg);
    end

    // R4: a cycle in which the lag setting moves is never compared.
    p_block_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lag_cfg) |-> !cmp_en);
endmodule

// File: rtl/lsc_capture.sv
`timescale 1ns/1ps
// Module: lsc_capture
// Holds the sticky fault flag, a saturating cycle counter and the
// record of the first mismatch (cycle index and XOR pattern).
// Assumes: diff is the XOR of the aligned words; cmp_en marks valid cycles.
module lsc_capture #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] diff,
    output logic              fault,
    output logic [CNT_W-1:0]  cap_cycle,
    output logic [DATA_W-1:0] cap_diff
);
    logic [CNT_W-1:0] cyc;
    logic             hit;

    assign hit = cmp_en && (diff != '0);

    // Count cycles since reset, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != '1) cyc <= cyc + CNT_W'(1);
    end

    // Latch the fault flag and keep it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   fault <= 1'b0;
        else if (hit) fault <= 1'b1;
    end

    // Record only the first discrepancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cycle <= '0;
            cap_diff  <= '0;
        end else if (hit && !fault) begin
            cap_cycle <= cyc;
            cap_diff  <= diff;
        end
    end

    // R5: the fault flag never drops without reset.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R6: the record is frozen once a fault is present.
    p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(cap_diff) && $stable(cap_cycle)));

    // R6: a recorded mismatch always has at least one differing bit.
    p_capture_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (cap_diff != '0));
endmodule

// File: rtl/lockstep_cmp.sv
`timescale 1ns/1ps
// Module: lockstep_cmp (top)
// Compares the primary core's bus, delayed by the configured lag, against
// the shadow core's bus. It applies optional single-bit fault injection on
// the shadow path and reports a sticky fault with a first-mismatch record.
// Assumes: both cores get identical inputs; the shadow core runs lag_cfg
// cycles behind the primary core.
module lockstep_cmp #(
    parameter int DATA_W  = lsc_pkg::LSC_DATA_W,
    parameter int MAX_LAG = lsc_pkg::LSC_MAX_LAG,
    parameter int CNT_W   = lsc_pkg::LSC_CNT_W,
    localparam int LAG_W  = $clog2(MAX_LAG + 1),
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAG_W-1:0]  lag_cfg,
    input  logic [DATA_W-1:0] main_bus,
    input  logic [DATA_W-1:0] shadow_bus,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_bit,
    output logic              fault,
    output logic [CNT_W-1:0]  cap_cycle,
    output logic [DATA_W-1:0] cap_diff
);
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] inj_mask;
    logic [DATA_W-1:0] shadow_eff;
    logic [DATA_W-1:0] diff;
    logic              cmp_en;

    lsc_delay_line #(.DATA_W(DATA_W), .MAX_LAG(MAX_LAG)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .lag   (lag_cfg),
        .din   (main_bus),
        .tap   (aligned)
    );

    lsc_align_ctrl #(.MAX_LAG(MAX_LAG)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .lag_cfg (lag_cfg),
        .cmp_en  (cmp_en)
    );

    // Build the self-test mask and apply it to the shadow path.
    always_comb begin
        inj_mask   = inj_en ? (DATA_W'(1) << inj_bit) : '0;
        shadow_eff = shadow_bus ^ inj_mask;
        diff       = aligned ^ shadow_eff;
    end

    lsc_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_en    (cmp_en),
        .diff      (diff),
        .fault     (fault),
        .cap_cycle (cap_cycle),
        .cap_diff  (cap_diff)
    );

    // R1: an enabled compare with any differing bit raises the fault next cycle.
    p_fault_on_mismatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (diff != '0)) |=> fault);
endmodule

// File: tb/sim_lockstep_cmp.sv
`timescale 1ns/1ps
// Bench for lockstep_cmp: random streams with a fixed seed plus directed
// corner cases, checked against a cycle model built from the requirements.
module sim_lockstep_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lag = 2'd0;
    logic [31:0] mb = '0;
    logic [31:0] sb = '0;
    logic        ie = 1'b0;
    logic [4:0]  ib = '0;
    logic        fault;
    logic [15:0] cc;
    logic [31:0] cd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state
    logic [31:0] mh [1:3];
    int          cyc;
    bit          prev_ok;
    logic [1:0]  prev_lag;
    int          run;
    bit          ef;
    logic [15:0] ecc;
    logic [31:0] ecd;

    always #10 clk = ~clk;

    lockstep_cmp u0 (
        .clk(clk), .rst_n(rst_n), .lag_cfg(lag), .main_bus(mb),
        .shadow_bus(sb), .inj_en(ie), .inj_bit(ib),
        .fault(fault), .cap_cycle(cc), .cap_diff(cd)
    );

    task automatic check(input string r, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    function automatic logic [31:0] past_main(input int d, input logic [31:0] m);
        return (d == 0) ? m : mh[d];
    endfunction

    // One cycle: drive at negedge, model, then check after the edge.
    task automatic tick(input logic [31:0] m, input logic [31:0] s,
                        input logic [1:0] l, input bit ie_i,
                        input logic [4:0] ib_i, input string r);
        logic [31:0] d;
        bit en;
        mb = m; sb = s; lag = l; ie = ie_i; ib = ib_i;
        if (prev_ok && l == prev_lag) run++; else run = 1;
        en = (run >= int'(l) + 2);
        d = past_main(int'(l), m) ^ s ^ (ie_i ? (32'd1 << ib_i) : 32'd0);
        if (en && d != 0 && !ef) begin
            ef = 1; ecc = cyc[15:0]; ecd = d;
        end
        @(posedge clk);
        @(negedge clk);
        check(r, {63'd0, fault}, {63'd0, ef}, "fault");
        if (ef) begin
            check(r, {48'd0, cc}, {48'd0, ecc}, "cap_cycle");
            check(r, {32'd0, cd}, {32'd0, ecd}, "cap_diff");
        end
        mh[3] = mh[2]; mh[2] = mh[1]; mh[1] = m;
        cyc++; prev_ok = 1; prev_lag = l;
    endtask

    task automatic do_reset(input logic [1:0] l);
        @(negedge clk);
        rst_n = 1'b0; lag = l; ie = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ef = 0; ecc = '0; ecd = '0; cyc = 0; prev_ok = 0; run = 0;
        for (int k = 1; k <= 3; k++) mh[k] = '0;
        check("R8", {63'd0, fault}, 64'd0, "reset fault");
        check("R8", {48'd0, cc}, 64'd0, "reset cap_cycle");
        check("R8", {32'd0, cd}, 64'd0, "reset cap_diff");
    endtask

    task automatic run_match(input int n, input logic [1:0] l, input string r);
        for (int i = 0; i < n; i++) begin
            logic [31:0] m;
            m = $urandom;
            tick(m, past_main(int'(l), m), l, 1'b0, 5'($urandom), r);
        end
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] m;
        void'($urandom(32'd20240611));
        do_reset(2'd0);

        // R1: lag 0 matching, then a mismatch
        run_match(40, 2'd0, "R1");
        m = $urandom;
        tick(m, m ^ 32'h00F0_0001, 2'd0, 1'b0, 5'd0, "R1");
        check("R1", {63'd0, fault}, 64'd1, "fault after mismatch");
        // R6: later mismatches leave the record
        tick(32'h1234_5678, 32'h0, 2'd0, 1'b0, 5'd0, "R6");
        check("R6", {32'd0, cd}, 64'h00F0_0001, "first pattern kept");
        // R5: sticky through matching traffic
        run_match(20, 2'd0, "R5");
        check("R5", {63'd0, fault}, 64'd1, "still set");
        do_reset(2'd0);
        check("R5", {63'd0, fault}, 64'd0, "cleared by reset");

        // R3: correct alignment for each lag, then wrong alignment
        for (int l = 1; l <= 3; l++) begin
            do_reset(2'(l));
            run_match(30, 2'(l), "R3");
            check("R3", {63'd0, fault}, 64'd0, "aligned no fault");
            m = $urandom;
            tick(m, past_main(l - 1, m), 2'(l), 1'b0, 5'd0, "R3");
            check("R3", {63'd0, fault}, 64'd1, "wrong lag detected");
        end

        // R4: garbage in the fill window after reset is ignored
        do_reset(2'd3);
        for (int t = 0; t < 4; t++) tick($urandom, $urandom, 2'd3, 1'b0, 5'd0, "R4");
        check("R4", {63'd0, fault}, 64'd0, "fill window after reset");
        run_match(8, 2'd3, "R4");
        // R4: lag change to 1 blocks the change cycle and one more
        for (int t = 0; t < 2; t++) tick($urandom, $urandom, 2'd1, 1'b0, 5'd0, "R4");
        check("R4", {63'd0, fault}, 64'd0, "fill window after change");
        run_match(6, 2'd1, "R4");
        m = $urandom;
        tick(m, ~past_main(1, m), 2'd1, 1'b0, 5'd0, "R4");
        check("R4", {63'd0, fault}, 64'd1, "enabled after window");

        // R2: each bit position
        for (int b = 0; b < 32; b++) begin
            logic [1:0] l;
            l = 2'(b % 4);
            do_reset(l);
            run_match(6, l, "R2");
            m = $urandom;
            tick(m, past_main(int'(l), m) ^ (32'd1 << b), l, 1'b0, 5'd0, "R2");
            check("R2", {32'd0, cd}, {32'd0, 32'd1 << b}, "single bit");
        end

        // R7: disabled injection has no effect, enabled one flips a bit
        do_reset(2'd0);
        run_match(20, 2'd0, "R7");
        check("R7", {63'd0, fault}, 64'd0, "inj_bit ignored");
        m = $urandom;
        tick(m, m ^ 32'h20, 2'd0, 1'b1, 5'd5, "R7");
        check("R7", {63'd0, fault}, 64'd0, "injection cancels flip");
        tick(m, m, 2'd0, 1'b1, 5'd7, "R7");
        check("R7", {32'd0, cd}, 64'h80, "injected bit seen");

        // Random mix of lags, resets and sparse corruption
        do_reset(2'd0);
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] l;
            logic [31:0] s;
            int r;
            r = int'($urandom % 100);
            if (r < 2) do_reset(2'($urandom));
            l = (r >= 2 && r < 6) ? 2'($urandom) : prev_lag;
            m = $urandom;
            s = past_main(int'(l), m);
            if ($urandom % 64 == 0) s = s ^ (32'd1 << ($urandom % 32));
            tick(m, s, l, ($urandom % 50 == 0), 5'($urandom), "R6");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule